// File: doc/BRIEF.md
# One-Hot Residue Adder-Subtractor

This block adds or subtracts two residues of one modulus. Both operands and the result are one-hot codes: a residue r in 0..M-1 is an M-bit vector with only bit r set. A sum is the first operand's vector rotated toward higher bit positions by the residue held in the second operand. A difference is the same rotation toward lower positions. The second operand's lines select among the M rotated copies directly, through an AND-OR network. No binary decode is needed, there is no carry, and the modular wrap is free. One control bit chooses between add and subtract. Any operand that is not a legal code makes the block raise an error flag and return an all-zero result.

The modulus is a parameter. The intended channels are the small moduli 3, 4 and 5, which come from 2^n-1, 2^n and 2^n+1 with n=2. The network grows with M squared, so large moduli are not a target.

Operands arrive on a valid/ready stream, and results leave on one. A transfer takes place on a rising edge where valid and ready are both high. When the output side holds ready low while a result is valid, the result and its flag stay unchanged until that result is taken. A parameter inserts one output register stage. Without it the path is combinational: ready passes straight back and valid passes straight forward.

Top module: `ohr_addsub`

## Requirements
- R1: A residue r is coded as an M-bit vector with bit r set and all other bits clear, so bit 0 is residue 0 and bit M-1 is residue M-1.
- R2: With `in_sub`=0 and legal operands, the result codes residue (a+b) mod M.
- R3: With `in_sub`=1 and legal operands, the result codes residue (a-b) mod M.
- R4: The modular wrap is exact at the edges: (M-1)+1 gives 0, 0-1 gives M-1, and a+0 or a-0 gives a.
- R5: If either operand has zero lines set or more than one line set, then `out_err`=1 and `out_res` is all zeros.
- R6: For legal operands, `out_err`=0 and `out_res` has exactly one line set.
- R7: An operand pair is accepted on a rising edge with `in_valid` and `in_ready` high. With REG_OUT=1 its result is presented with `out_valid`=1 from that edge on, and results leave in the order they were accepted.
- R8: With REG_OUT=1, while `out_valid`=1 and `out_ready`=0, `out_res`, `out_err` and `out_valid` hold, and `in_ready` is 0. When the stage is empty, or is being drained, `in_ready` is 1.
- R9: While reset is asserted and right after it, `out_valid` is 0 and, with REG_OUT=1, `in_ready` is 1.
- R10: With REG_OUT=0 the block is combinational for moduli 3 and 4: `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and the result follows the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can accept the operand pair |
| in_a | input | M | First operand, one-hot |
| in_b | input | M | Second operand (rotation amount), one-hot |
| in_sub | input | 1 | 0 selects add, 1 selects subtract |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | M | Result residue, one-hot, zero on error |
| out_err | output | 1 | An operand was not a legal one-hot code |

## Verification
The hardest case to reach from the ports is a stalled output stage that holds an error result while a new operand pair waits upstream. That case checks that holding, flagging and zero masking work together. The stimulus throttles `out_ready` with a repeating pattern, and during that throttled phase it mixes illegal codes (empty, two-hot and all-ones vectors) into the legal operand pairs. A scoreboard queue then confirms the order and content of every result, including the wrap edges.

// File: rtl/ohr_pkg.sv
package ohr_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  // index of the source line feeding output line k when rotating by j
  function automatic int src_idx(input int k, input int j, input int m, input bit sub);
    if (sub) return (k + j) % m;
    return (k - j + m) % m;
  endfunction
endpackage

// File: rtl/ohr_code_check.sv
module ohr_code_check #(
  parameter int M = 5
) (
  input  logic [M-1:0] code,
  output logic         legal
);
  logic seen_one;
  logic seen_two;

  always_comb begin
    seen_one = 1'b0;
    seen_two = 1'b0;
    for (int i = 0; i < M; i++) begin
      seen_two = seen_two | (seen_one & code[i]);
      seen_one = seen_one | code[i];
    end
    legal = seen_one & ~seen_two;
  end
endmodule

// File: rtl/ohr_rotator.sv
module ohr_rotator
  import ohr_pkg::*;
#(
  parameter int M = 5
) (
  input  logic [M-1:0] vec,
  input  logic [M-1:0] amt,
  input  op_e          op,
  output logic [M-1:0] res
);
  localparam int TERMS = M * M;

  logic [TERMS-1:0] up_t;
  logic [TERMS-1:0] dn_t;

  for (genvar k = 0; k < M; k++) begin : g_line
    for (genvar j = 0; j < M; j++) begin : g_amt
      localparam int UP_SRC = src_idx(k, j, M, 1'b0);
      localparam int DN_SRC = src_idx(k, j, M, 1'b1);
      assign up_t[k*M+j] = amt[j] & vec[UP_SRC];
      assign dn_t[k*M+j] = amt[j] & vec[DN_SRC];
    end
    assign res[k] = (op == OP_SUB) ? |dn_t[k*M +: M] : |up_t[k*M +: M];
  end
endmodule

// File: rtl/ohr_out_stage.sv
module ohr_out_stage #(
  parameter int M       = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [M-1:0] up_res,
  input  logic         up_err,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [M-1:0] dn_res,
  output logic         dn_err
);
  if (REG_OUT) begin : g_reg
    logic         full_q;
    logic [M-1:0] res_q;
    logic         err_q;

    assign up_ready = ~full_q | dn_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        res_q  <= '0;
        err_q  <= 1'b0;
      end else if (up_ready) begin
        full_q <= up_valid;
        if (up_valid) begin
          res_q <= up_res;
          err_q <= up_err;
        end
      end
    end

    assign dn_valid = full_q;
    assign dn_res   = res_q;
    assign dn_err   = err_q;
  end else begin : g_comb
    assign up_ready = dn_ready;
    assign dn_valid = up_valid;
    assign dn_res   = up_res;
    assign dn_err   = up_err;
  end
endmodule

// File: rtl/ohr_addsub.sv
module ohr_addsub
  import ohr_pkg::*;
#(
  parameter int M       = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] in_a,
  input  logic [M-1:0] in_b,
  input  logic         in_sub,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [M-1:0] out_res,
  output logic         out_err
);
  logic         a_legal;
  logic         b_legal;
  logic         bad;
  logic [M-1:0] rot;
  logic [M-1:0] masked;
  op_e          op;

  assign op = op_e'(in_sub);

  ohr_code_check #(.M(M)) chk_a_i (.code(in_a), .legal(a_legal));
  ohr_code_check #(.M(M)) chk_b_i (.code(in_b), .legal(b_legal));

  ohr_rotator #(.M(M)) rot_i (
    .vec(in_a),
    .amt(in_b),
    .op (op),
    .res(rot)
  );

  assign bad    = ~(a_legal & b_legal);
  assign masked = bad ? '0 : rot;

  ohr_out_stage #(.M(M), .REG_OUT(REG_OUT)) stage_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_res  (masked),
    .up_err  (bad),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_res  (out_res),
    .dn_err  (out_err)
  );
endmodule

// File: rtl/ohr_addsub_chk.sv
module ohr_addsub_chk #(
  parameter int M       = 5,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [M-1:0] in_a,
  input logic [M-1:0] in_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [M-1:0] out_res,
  input logic         out_err
);
  AST_RES_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> ($countones(out_res) == 1)); // R6

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_res == '0)); // R5

  if (REG_OUT) begin : g_reg_chk
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_err))); // R8

    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready); // R8

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid); // R7

    AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && (($countones(in_a) != 1) || ($countones(in_b) != 1))) |=> out_err); // R5

    always @(negedge clk) begin
      if (!rst_n) begin
        AST_RESET_IDLE: assert (!out_valid && in_ready); // R9
      end
    end
  end else begin : g_comb_chk
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (in_ready == out_ready)); // R10
  end
endmodule

bind ohr_addsub ohr_addsub_chk #(.M(M), .REG_OUT(REG_OUT)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_a     (in_a),
  .in_b     (in_b),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_res  (out_res),
  .out_err  (out_err)
);

// File: tb/ohr_addsub_tb.sv
module ohr_addsub_tb_top;
  localparam int M = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [M-1:0] in_a = '0;
  logic [M-1:0] in_b = '0;
  logic         in_sub = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [M-1:0] out_res;
  logic         out_err;

  // combinational instances, moduli 3 and 4
  logic       c3_valid = 1'b0, c3_ready, c3_ovalid, c3_oready = 1'b0, c3_err, c3_sub = 1'b0;
  logic [2:0] c3_a = '0, c3_b = '0, c3_res;
  logic       c4_valid = 1'b0, c4_ready, c4_ovalid, c4_oready = 1'b0, c4_err, c4_sub = 1'b0;
  logic [3:0] c4_a = '0, c4_b = '0, c4_res;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit stall = 1'b0;
  bit finished = 1'b0;

  logic [M:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  ohr_addsub #(.M(M), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sub(in_sub), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_err(out_err));

  ohr_addsub #(.M(3), .REG_OUT(1'b0)) dut_m3 (
    .clk(clk), .rst_n(rst_n), .in_valid(c3_valid), .in_ready(c3_ready),
    .in_a(c3_a), .in_b(c3_b), .in_sub(c3_sub), .out_valid(c3_ovalid),
    .out_ready(c3_oready), .out_res(c3_res), .out_err(c3_err));

  ohr_addsub #(.M(4), .REG_OUT(1'b0)) dut_m4 (
    .clk(clk), .rst_n(rst_n), .in_valid(c4_valid), .in_ready(c4_ready),
    .in_a(c4_a), .in_b(c4_b), .in_sub(c4_sub), .out_valid(c4_ovalid),
    .out_ready(c4_oready), .out_res(c4_res), .out_err(c4_err));

  function automatic int ref_res(int m, int a, int b, bit sub);
    if (sub) return (a - b + m) % m;
    return (a + b) % m;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: present a pair, wait for acceptance, push the expected result
  task automatic send(logic [M-1:0] a, logic [M-1:0] b, bit sub, logic [M:0] exp, string tag);
    @(negedge clk);
    in_a = a; in_b = b; in_sub = sub; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  task automatic send_legal(int a, int b, bit sub);
    int r;
    string t;
    r = ref_res(M, a, b, sub);
    if ((a == M-1 && b == 1 && !sub) || (a == 0 && b == 1 && sub) || b == 0) t = "R4 wrap edge";
    else if (sub) t = "R3 subtract";
    else t = "R2 add";
    send(M'(1) << a, M'(1) << b, sub, {1'b0, M'(1) << r}, t);
  endtask

  // monitor / scoreboard
  logic         prev_stall = 1'b0;
  logic [M-1:0] prev_res = '0;
  logic         prev_err = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      out_ready = stall ? (cyc % 3 == 0) : 1'b1;
      cyc++;
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          check(out_valid && out_res == prev_res && out_err == prev_err,
                "R8 held under stall", {out_valid, out_err, out_res}, {1'b1, prev_err, prev_res});
        end
        if (out_valid && !out_ready)
          check(!in_ready, "R8 in_ready low when full", in_ready, 0);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected result", {out_err, out_res}, 0);
          end else begin
            logic [M:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({out_err, out_res} == e, t, {out_err, out_res}, e);
            if (!e[M]) check($countones(out_res) == 1, "R6 one line", out_res, e[M-1:0]);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_res   = out_res;
        prev_err   = out_err;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R9 out_valid in reset", out_valid, 0);
    check(in_ready, "R9 in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid, "R9 out_valid after reset", out_valid, 0);

    // R7: latency of one register with an empty stage
    send_legal(2, 1, 1'b0);
    check(out_valid, "R7 result visible after accept", out_valid, 1);

    // R2 R3 R4: every pair, full throughput
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < M; a++)
        for (int b = 0; b < M; b++)
          send_legal(a, b, s[0]);

    // R5 R8: throttled output with illegal codes mixed in
    stall = 1'b1;
    send(5'b00000, 5'b00010, 1'b0, {1'b1, 5'b0}, "R5 empty a");
    send_legal(4, 3, 1'b0);
    send(5'b00100, 5'b01010, 1'b1, {1'b1, 5'b0}, "R5 two-hot b");
    send(5'b11111, 5'b11111, 1'b0, {1'b1, 5'b0}, "R5 all ones");
    send_legal(0, 4, 1'b1);
    send(5'b00001, 5'b00000, 1'b1, {1'b1, 5'b0}, "R5 empty b");
    for (int a = 0; a < M; a++) send_legal(a, (a * 2) % M, a[0]);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (12) @(negedge clk);
    stall = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7 all results delivered in order", exp_q.size(), 0);

    // R10 R1: combinational channels for moduli 3 and 4
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++) begin
          c3_a = 3'(1) << a; c3_b = 3'(1) << b; c3_sub = s[0];
          c3_valid = a[0]; c3_oready = b[0];
          #1;
          check(c3_res == (3'(1) << ref_res(3, a, b, s[0])) && !c3_err,
                "R10 R1 modulus 3 result", c3_res, 3'(1) << ref_res(3, a, b, s[0]));
          check(c3_ovalid == c3_valid && c3_ready == c3_oready,
                "R10 modulus 3 pass-through", {c3_ovalid, c3_ready}, {c3_valid, c3_oready});
        end
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          c4_a = 4'(1) << a; c4_b = 4'(1) << b; c4_sub = s[0];
          c4_valid = b[0]; c4_oready = a[0];
          #1;
          check(c4_res == (4'(1) << ref_res(4, a, b, s[0])) && !c4_err,
                "R10 R1 modulus 4 result", c4_res, 4'(1) << ref_res(4, a, b, s[0]));
          check(c4_ovalid == c4_valid && c4_ready == c4_oready,
                "R10 modulus 4 pass-through", {c4_ovalid, c4_ready}, {c4_valid, c4_oready});
        end
    c4_a = 4'b0110; c4_b = 4'b0001;
    #1;
    check(c4_err && c4_res == 4'b0, "R5 modulus 4 two-hot a", {c4_err, c4_res}, 5'b10000);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule